// File: doc/BRIEF.md
# Interconnect Performance Counter Unit

This block counts activity for one clock domain of an on-chip interconnect. It has eight 32-bit event counters and one free-running 64-bit cycle counter. Each event counter has a selector register that names one interface node by a 4-bit type and a 9-bit ID. The counter advances on cycles where that node's event line is high. The event lines reach the block already filtered by the per-node selection logic, which lies outside this block. Each node's type/ID tag is supplied on a static input vector at integration time.

Software reaches the unit over a simple 32-bit register port with a combinational read path. Count enables, interrupt enables and overflow flags each use a pair of addresses: one that sets bits and one that clears them. The event counters use bits 0..7 of these masks and the cycle counter uses bit 31. A single level interrupt is raised while an enabled overflow flag is pending.

The cycle counter is read as two words. If the upper word changes between the two reads, software reads again.

Top module: `ic_perf_unit`

## Requirements
- R1: After reset, all counters, selectors, enables, interrupt enables and overflow flags are zero, and `irq` is low. The read-only word at 0xE00 reads 0x0000_2008: bits 5:0 give the counter count (8) and bits 15:8 give the counter width (32).
- R2: Event counter n (read/write at 0x008+8n) adds one on each clock in which three things hold: control bit 0 is 1, enable bit n is 1, and some node whose tag exactly equals selector n (bits 12:9 type, bits 8:0 ID) has its event line high. Selector n is at 0x400+4n and reads back only bits 12:0.
- R3: An event counter that advances from 0xFFFFFFFF becomes 0 and sets overflow bit n.
- R4: The cycle counter adds one on every clock in which control bit 0 and enable bit 31 are both 1. Its low word is at 0x0F8 and its high word at 0x0FC. Writing each word loads that half. Advancing from all ones gives 0 and sets overflow bit 31.
- R5: Writing 1s to 0xC00 sets count enables, and writing 1s to 0xC20 clears them. Zero bits leave enables unchanged. Only bits 0..7 and 31 exist, so both addresses read back the mask, with the other bits read as 0.
- R6: Interrupt enables use 0xC40 (set) and 0xC60 (clear), with the same bit mapping and readback as the count enables.
- R7: Overflow flags read at 0xC80 and at 0xCC0. Writing 1s to 0xC80 clears flags and writing 1s to 0xCC0 sets them. A flag stays set until it is cleared. A wrap in the same cycle as a clear leaves the flag set.
- R8: Control at 0xE04: bit 0 is the global enable and reads back. Writing 1 to bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter. Both reset bits read back as 0, and the zeroing wins over counting in that cycle.
- R9: `irq` is high exactly when some overflow flag and its interrupt enable are both set.
- R10: While control bit 0 is 0, no counter advances, whatever the enables and event lines are.
- R11: Reads of any unmapped byte offset return 0, and writes to such offsets change nothing. This includes the odd words 0x00C+8n between event counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_sel` is high with `bus_wr` low |
| node_tag | input | NODES*13 | Per-node {type[3:0], id[8:0]} tags, node 0 in the low bits |
| node_evt | input | NODES | Per-node filtered event pulses |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are the wraps: 2^32 events or 2^64 clocks are out of reach in simulation. The bench therefore loads each counter to a few counts below all ones through the register port. It then opens the global enable for a known number of clocks and checks both the wrapped value and the overflow flag. The carry out of the cycle counter's low word gets its own check, which confirms that crossing into the high word leaves overflow bit 31 clear.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int TYPE_W  = 4;
    localparam int ID_W    = 9;
    localparam int TAG_W   = TYPE_W + ID_W;
    localparam int CYC_BIT = 31;
    localparam int CYC_W   = 64;

    localparam logic [ADDR_W-1:0] OFS_CYC_LO = 12'h0F8;
    localparam logic [ADDR_W-1:0] OFS_CYC_HI = 12'h0FC;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'hC00;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'hC20;
    localparam logic [ADDR_W-1:0] OFS_IE_SET = 12'hC40;
    localparam logic [ADDR_W-1:0] OFS_IE_CLR = 12'hC60;
    localparam logic [ADDR_W-1:0] OFS_OV_CLR = 12'hC80;
    localparam logic [ADDR_W-1:0] OFS_OV_SET = 12'hCC0;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 12'hE00;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'hE04;

    function automatic logic [ADDR_W-1:0] evc_ofs(input int n);
        return ADDR_W'(32'h008 + 32'(n) * 8);
    endfunction

    function automatic logic [ADDR_W-1:0] sel_ofs(input int n);
        return ADDR_W'(32'h400 + 32'(n) * 4);
    endfunction
endpackage

// File: rtl/icpu_evt_sel.sv
module icpu_evt_sel
    import icpu_pkg::*;
#(
    parameter int NODES = 4
) (
    input  logic [TAG_W-1:0]       sel_tag,
    input  logic [NODES*TAG_W-1:0] node_tag,
    input  logic [NODES-1:0]       node_evt,
    output logic                   hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            if (node_evt[i] && (node_tag[i*TAG_W +: TAG_W] == sel_tag)) begin
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/icpu_cyc_cnt.sv
module icpu_cyc_cnt
    import icpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              clr,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CYC_W-1:0]  val,
    output logic              wrap
);
    logic [CYC_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        wrap  = 1'b0;
        if (clr) begin
            val_d = '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) val_d[DATA_W-1:0]     = wdata;
            if (ld_hi) val_d[CYC_W-1:DATA_W] = wdata;
        end else if (inc) begin
            val_d = val_q + 1'b1;
            wrap  = &val_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;
endmodule

// File: rtl/ic_perf_unit.sv
module ic_perf_unit
    import icpu_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int NODES   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NODES*TAG_W-1:0] node_tag,
    input  logic [NODES-1:0]       node_evt,
    output logic                   irq
);
    localparam logic [DATA_W-1:0] BIT_MASK =
        (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_EVT) - 1'b1);
    localparam logic [DATA_W-1:0] CFG_VAL  = DATA_W'((DATA_W << 8) | NUM_EVT);

    typedef struct packed {
        logic [NUM_EVT-1:0][DATA_W-1:0] evc;
        logic [NUM_EVT-1:0][TAG_W-1:0]  sel;
        logic [DATA_W-1:0]              cnten;
        logic [DATA_W-1:0]              inten;
        logic [DATA_W-1:0]              ovf;
        logic                           glb_en;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_EVT-1:0] hit;
    logic               wr_acc;
    logic               cyc_inc, cyc_clr, cyc_ld_lo, cyc_ld_hi, cyc_wrap;
    logic [CYC_W-1:0]   cyc_val;
    logic               glb_en_w;
    logic [DATA_W-1:0]  ovf_w;

    assign wr_acc   = bus_sel && bus_wr;
    assign glb_en_w = st_q.glb_en;
    assign ovf_w    = st_q.ovf;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_sel
        icpu_evt_sel #(.NODES(NODES)) u_sel (
            .sel_tag  (st_q.sel[g]),
            .node_tag (node_tag),
            .node_evt (node_evt),
            .hit      (hit[g])
        );
    end

    assign cyc_inc   = glb_en_w && st_q.cnten[CYC_BIT];
    assign cyc_clr   = wr_acc && (bus_addr == OFS_CTRL) && bus_wdata[2];
    assign cyc_ld_lo = wr_acc && (bus_addr == OFS_CYC_LO);
    assign cyc_ld_hi = wr_acc && (bus_addr == OFS_CYC_HI);

    icpu_cyc_cnt u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cyc_inc),
        .clr   (cyc_clr),
        .ld_lo (cyc_ld_lo),
        .ld_hi (cyc_ld_hi),
        .wdata (bus_wdata),
        .val   (cyc_val),
        .wrap  (cyc_wrap)
    );

    always_comb begin
        logic [NUM_EVT-1:0] evt_wrap;
        logic [DATA_W-1:0]  wmask;
        st_d     = st_q;
        evt_wrap = '0;
        wmask    = bus_wdata & BIT_MASK;

        for (int n = 0; n < NUM_EVT; n++) begin
            if (glb_en_w && st_q.cnten[n] && hit[n]) begin
                st_d.evc[n] = st_q.evc[n] + 1'b1;
                evt_wrap[n] = &st_q.evc[n];
            end
        end

        if (wr_acc) begin
            for (int n = 0; n < NUM_EVT; n++) begin
                if (bus_addr == evc_ofs(n)) begin
                    st_d.evc[n] = bus_wdata;
                    evt_wrap[n] = 1'b0;
                end
                if (bus_addr == sel_ofs(n)) st_d.sel[n] = bus_wdata[TAG_W-1:0];
            end
            case (bus_addr)
                OFS_EN_SET: st_d.cnten = st_q.cnten | wmask;
                OFS_EN_CLR: st_d.cnten = st_q.cnten & ~wmask;
                OFS_IE_SET: st_d.inten = st_q.inten | wmask;
                OFS_IE_CLR: st_d.inten = st_q.inten & ~wmask;
                OFS_OV_CLR: st_d.ovf   = st_q.ovf & ~wmask;
                OFS_OV_SET: st_d.ovf   = st_q.ovf | wmask;
                OFS_CTRL: begin
                    st_d.glb_en = bus_wdata[0];
                    if (bus_wdata[1]) begin
                        st_d.evc = '0;
                        evt_wrap = '0;
                    end
                end
                default: ;
            endcase
        end

        st_d.ovf[NUM_EVT-1:0] = st_d.ovf[NUM_EVT-1:0] | evt_wrap;
        st_d.ovf[CYC_BIT]     = st_d.ovf[CYC_BIT] | cyc_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int n = 0; n < NUM_EVT; n++) begin
                if (bus_addr == evc_ofs(n)) bus_rdata = st_q.evc[n];
                if (bus_addr == sel_ofs(n)) bus_rdata = DATA_W'(st_q.sel[n]);
            end
            case (bus_addr)
                OFS_CYC_LO:             bus_rdata = cyc_val[DATA_W-1:0];
                OFS_CYC_HI:             bus_rdata = cyc_val[CYC_W-1:DATA_W];
                OFS_EN_SET, OFS_EN_CLR: bus_rdata = st_q.cnten;
                OFS_IE_SET, OFS_IE_CLR: bus_rdata = st_q.inten;
                OFS_OV_CLR, OFS_OV_SET: bus_rdata = ovf_w;
                OFS_CFG:                bus_rdata = CFG_VAL;
                OFS_CTRL:               bus_rdata = DATA_W'(glb_en_w);
                default: ;
            endcase
        end
    end

    assign irq = |(ovf_w & st_q.inten);
endmodule

// File: rtl/icpu_checker.sv
module icpu_checker
    import icpu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              glb_en,
    input logic              cyc_inc,
    input logic [CYC_W-1:0]  cyc_val,
    input logic [DATA_W-1:0] ovf
);
    logic wr_any;
    assign wr_any = bus_sel && bus_wr;

    // R4: one step per enabled clock
    a_r4_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_inc && !wr_any) |=> (cyc_val == $past(cyc_val) + 64'd1));

    // R4: wrap raises flag 31
    a_r4_cyc_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_inc && !wr_any && (&cyc_val)) |=> ovf[CYC_BIT]);

    // R10: global enable low freezes the cycle counter
    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !wr_any) |=> $stable(cyc_val));

    // R8: reset bit 2 zeroes the cycle counter
    a_r8_cyc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == OFS_CTRL && bus_wdata[2]) |=> (cyc_val == '0));

    // R7: flags are sticky without a write
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[CYC_BIT] && !wr_any) |=> ovf[CYC_BIT]);

    // R11: hole between counters and selectors reads zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr inside {[12'h100:12'h3FC]})) |-> (bus_rdata == '0));
endmodule

bind ic_perf_unit icpu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .glb_en    (glb_en_w),
    .cyc_inc   (cyc_inc),
    .cyc_val   (cyc_val),
    .ovf       (ovf_w)
);

// File: tb/ic_perf_unit_tb.sv
module ic_perf_unit_tb;
    localparam int NODES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NODES*13-1:0] node_tag;
    logic [NODES-1:0]    node_evt = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rv;

    // node0 type4/id3, node1 type5/id3, node2 type4/id7, node3 type7/id511
    assign node_tag = {13'hFFF, 13'h807, 13'hA03, 13'h803};

    always #10 clk = ~clk;

    ic_perf_unit #(.NUM_EVT(8), .NODES(NODES)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .node_tag(node_tag), .node_evt(node_evt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input int idx, input int k);
        for (int i = 0; i < k; i++) begin
            node_evt[idx] = 1'b1;
            @(negedge clk);
            node_evt[idx] = 1'b0;
        end
    endtask

    task automatic t_reset();
        rd32(12'h008, rv); check("R1 counter0", rv, 32'h0);
        rd32(12'h0F8, rv); check("R1 cyc lo", rv, 32'h0);
        rd32(12'hC00, rv); check("R1 enables", rv, 32'h0);
        rd32(12'hC80, rv); check("R1 overflow", rv, 32'h0);
        rd32(12'hE04, rv); check("R1 control", rv, 32'h0);
        rd32(12'hE00, rv); check("R1 config", rv, 32'h0000_2008);
        check("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_count();
        wr32(12'h400, 32'h803);
        wr32(12'h404, 32'hA03);
        wr32(12'hC00, 32'h3);
        wr32(12'hE04, 32'h1);
        pulse(0, 5);
        pulse(2, 4);
        pulse(1, 3);
        pulse(3, 2);
        rd32(12'h008, rv); check("R2 counter0 match", rv, 32'd5);
        rd32(12'h010, rv); check("R2 counter1 match", rv, 32'd3);
        rd32(12'h0F8, rv); check("R4 cyc idle without bit31", rv, 32'h0);
        wr32(12'h404, 32'hFFFF_FFFF);
        rd32(12'h404, rv); check("R2 selector width", rv, 32'h1FFF);
        wr32(12'h404, 32'hA03);
    endtask

    task automatic t_off();
        wr32(12'hE04, 32'h0);
        pulse(0, 4);
        rd32(12'h008, rv); check("R10 no count when off", rv, 32'd5);
    endtask

    task automatic t_enables();
        wr32(12'hE04, 32'h1);
        wr32(12'hC20, 32'h1);
        wr32(12'hC00, 32'h0);
        pulse(0, 2);
        pulse(1, 2);
        rd32(12'h008, rv); check("R5 cleared enable", rv, 32'd5);
        rd32(12'h010, rv); check("R5 kept enable", rv, 32'd5);
        rd32(12'hC20, rv); check("R5 enable readback", rv, 32'h2);
        wr32(12'hE04, 32'h0);
        wr32(12'hC00, 32'hFFFF_FFFF);
        rd32(12'hC00, rv); check("R5 enable mask", rv, 32'h8000_00FF);
        wr32(12'hC20, 32'hFFFF_FFFF);
        rd32(12'hC00, rv); check("R5 enable clear all", rv, 32'h0);
    endtask

    task automatic t_wrap();
        wr32(12'h0F8, 32'h0);
        wr32(12'h0FC, 32'h0);
        wr32(12'hC00, 32'h1);
        wr32(12'h008, 32'hFFFF_FFFE);
        wr32(12'hE04, 32'h1);
        pulse(0, 2);
        rd32(12'h008, rv); check("R3 wrap value", rv, 32'h0);
        rd32(12'hC80, rv); check("R3 wrap flag", rv, 32'h1);
        check("R9 irq masked", 32'(irq), 32'h0);
        wr32(12'hC40, 32'h1);
        check("R9 irq raised", 32'(irq), 32'h1);
        rd32(12'hC60, rv); check("R6 inten readback", rv, 32'h1);
        wr32(12'hC80, 32'h1);
        rd32(12'hCC0, rv); check("R7 w1c", rv, 32'h0);
        check("R9 irq dropped", 32'(irq), 32'h0);
        wr32(12'hCC0, 32'h8000_0000);
        rd32(12'hC80, rv); check("R7 w1s", rv, 32'h8000_0000);
        check("R9 irq other bit", 32'(irq), 32'h0);
        wr32(12'hC40, 32'h8000_0000);
        check("R6 irq bit31", 32'(irq), 32'h1);
        wr32(12'hC60, 32'hFFFF_FFFF);
        check("R6 inten clear", 32'(irq), 32'h0);
        wr32(12'hC80, 32'hFFFF_FFFF);
        wr32(12'hE04, 32'h0);
    endtask

    task automatic t_cycles();
        wr32(12'hC20, 32'hFFFF_FFFF);
        wr32(12'hC00, 32'h8000_0000);
        wr32(12'h0F8, 32'hFFFF_FFFE);
        wr32(12'h0FC, 32'h0000_0001);
        rd32(12'h0FC, rv); check("R4 load hi", rv, 32'h1);
        wr32(12'hE04, 32'h1);
        repeat (3) @(negedge clk);
        wr32(12'hE04, 32'h0);           // four counted edges
        rd32(12'h0F8, rv); check("R4 carry lo", rv, 32'h2);
        rd32(12'h0FC, rv); check("R4 carry hi", rv, 32'h2);
        rd32(12'hC80, rv); check("R4 no flag on half carry", rv, 32'h0);
        wr32(12'h0F8, 32'hFFFF_FFFE);
        wr32(12'h0FC, 32'hFFFF_FFFF);
        wr32(12'hE04, 32'h1);
        repeat (1) @(negedge clk);
        wr32(12'hE04, 32'h0);           // two counted edges
        rd32(12'h0F8, rv); check("R4 wrap lo", rv, 32'h0);
        rd32(12'h0FC, rv); check("R4 wrap hi", rv, 32'h0);
        rd32(12'hC80, rv); check("R4 wrap flag", rv, 32'h8000_0000);
        wr32(12'hC80, 32'hFFFF_FFFF);
    endtask

    task automatic t_ctrl_reset();
        wr32(12'hC20, 32'hFFFF_FFFF);
        wr32(12'h008, 32'h1234);
        wr32(12'h010, 32'h7);
        wr32(12'h0F8, 32'h5);
        wr32(12'hE04, 32'h3);
        rd32(12'h008, rv); check("R8 evc zero c0", rv, 32'h0);
        rd32(12'h010, rv); check("R8 evc zero c1", rv, 32'h0);
        rd32(12'h0F8, rv); check("R8 cyc untouched", rv, 32'h5);
        rd32(12'hE04, rv); check("R8 reset bits read 0", rv, 32'h1);
        wr32(12'hE04, 32'h4);
        rd32(12'h0F8, rv); check("R8 cyc zero", rv, 32'h0);
        rd32(12'hE04, rv); check("R8 enable cleared", rv, 32'h0);
    endtask

    task automatic t_unmapped();
        wr32(12'h200, 32'hDEAD_BEEF);
        rd32(12'h200, rv); check("R11 hole read", rv, 32'h0);
        wr32(12'h00C, 32'hDEAD_BEEF);
        rd32(12'h00C, rv); check("R11 odd word", rv, 32'h0);
        rd32(12'h008, rv); check("R11 neighbour intact", rv, 32'h0);
        rd32(12'hE00, rv); check("R11 config intact", rv, 32'h0000_2008);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL all: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_off();
        t_enables();
        t_wrap();
        t_cycles();
        t_ctrl_reset();
        t_unmapped();
        summary();
        $finish;
    end
endmodule